// File: doc/BRIEF.md
# Down-Counting PWM Timer with Deferred Period and Compare Reload

This block generates a pulse-width-modulated waveform from a 24-bit down counter. The count is a 16-bit word widened by an 8-bit upper byte. Two values drive it: a period (load) value that the counter reloads from on reaching zero, and a compare (match) value below which the raw output is high. Software writes these values through a small register write port. For each value it chooses separately whether a new setting acts at once or waits for the next timeout. In timeout mode the new values are held until the counter reaches zero. When both values wait, they land together at that one reload. A new period that is shorter than the old compare value therefore never produces a cut, stretched or doubled pulse.

The low 16 bits of each value are staged in a shadow register. A write to the commit address supplies both upper bytes and releases the staged period and compare values together, so a half-written 24-bit value is never used. Re-enabling a stopped timer applies any values still waiting at once, without waiting for a timeout. An invert bit flips the output polarity. A one-cycle timeout pulse marks each reload.

Top module: `pwm_deferred_timer`

## Requirements
- R1: After reset the timer is disabled, both update modes are immediate, the invert bit is 0, `pwm_out` is 0 and `timeout` is 0.
- R2: While enabled, the counter decrements by one per clock. In the cycle where it is zero, `timeout` is 1 and the counter reloads from the period value P. Timeouts therefore repeat every P+1 cycles.
- R3: Before inversion the output is high in exactly the cycles where the count is at or below the compare value M. This gives M+1 high cycles per period when M < P. When M >= P the output is high for the whole period.
- R4: Control bit 3 (invert) set to 1 inverts `pwm_out`, giving P-M low-to-high complemented cycles (P-M high cycles when M < P).
- R5: With control bit 1 = 0 (period immediate), a commit loads the new period into the running counter in the next cycle.
- R6: With control bit 1 = 1 (period deferred), a committed period is held and takes effect only at the next zero-count reload. The running period finishes unchanged.
- R7: Control bit 2 selects the compare update mode (0 immediate, 1 at timeout), independently of bit 1. An immediate compare changes the output in the next cycle even while a period is still waiting.
- R8: The registers are: address 0 control (bit 0 enable, bit 1 period deferred, bit 2 compare deferred, bit 3 invert); address 1 the low 16 bits of the period; address 2 the low 16 bits of the compare value; address 3 a commit, whose data bits [7:0] become the period upper byte and bits [15:8] the compare upper byte. A write to address 1 or 2 alone changes nothing at the output.
- R9: When both values are deferred and the new period is below the old compare value, the period in progress keeps its old length and high time. The next period uses the new period and the new compare value together.
- R10: A write to address 0 that sets enable while the timer is stopped applies any waiting values at once and starts counting from the new period.
- R11: While disabled, the count holds, `timeout` is 0 and `pwm_out` equals the invert bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 period low, 2 compare low, 3 commit) |
| wr_data | input | 16 | Write data |
| pwm_out | output | 1 | PWM output after optional inversion |
| timeout | output | 1 | High in the reload cycle at zero count |

## Verification
The hardest case to reach is a commit of a short period below the old compare value while both values are deferred. The commit must land in the middle of a long period, and the checks must then see the unchanged old period, followed at once by the new period with the new high time. The stimulus waits for a timeout pulse, writes both staged values and commits them within the first few cycles of a 31-cycle period. It then measures the lengths of the next two periods and their high-cycle counts at the pins. A behavioural model compares both outputs on every clock, including across the re-enable of a stopped timer that still holds waiting values.

// File: rtl/pwm_dr_pkg.sv
package pwm_dr_pkg;
   typedef enum logic [1:0] {
      ADR_CTRL     = 2'd0,
      ADR_LOAD_LO  = 2'd1,
      ADR_MATCH_LO = 2'd2,
      ADR_COMMIT   = 2'd3
   } adr_e;

   typedef struct packed {
      logic invert;
      logic mdefer;
      logic ldefer;
      logic en;
   } ctrl_t;
endpackage

// File: rtl/pwm_dr_shadow.sv
module pwm_dr_shadow #(
   parameter int LO_W = 16,
   parameter int HI_W = 8,
   localparam int W = LO_W + HI_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            stage_lo,
   input  logic [LO_W-1:0] lo_data,
   input  logic            commit,
   input  logic [HI_W-1:0] hi_data,
   input  logic            defer,
   input  logic            reload,
   input  logic            restart,
   output logic [W-1:0]    act_next,
   output logic [W-1:0]    active,
   output logic            pending
);
   logic [LO_W-1:0] lo_q;
   logic [W-1:0]    pend_q, pend_d, act_q, act_d;
   logic            pend_f, pend_fd;
   logic [W-1:0]    commit_val;

   assign commit_val = {hi_data, lo_q};

   always_comb begin
      act_d   = act_q;
      pend_d  = pend_q;
      pend_fd = pend_f;
      if (commit) begin
         if (defer) begin
            pend_d  = commit_val;
            pend_fd = 1'b1;
         end else begin
            act_d   = commit_val;
            pend_fd = 1'b0;
         end
      end else if ((reload || restart) && pend_f) begin
         act_d   = pend_q;
         pend_fd = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q   <= '0;
         pend_q <= '0;
         act_q  <= '0;
         pend_f <= 1'b0;
      end else begin
         if (stage_lo) lo_q <= lo_data;
         pend_q <= pend_d;
         act_q  <= act_d;
         pend_f <= pend_fd;
      end
   end

   assign act_next = act_d;
   assign active   = act_q;
   assign pending  = pend_f;

   // R6
   defer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_f && !reload && !restart && !commit) |=> $stable(act_q));

   // R7
   imm_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !defer) |=> (act_q == $past(commit_val)));
endmodule

// File: rtl/pwm_dr_counter.sv
module pwm_dr_counter #(
   parameter int W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         start,
   input  logic         force_ld,
   input  logic [W-1:0] load_next,
   output logic [W-1:0] cnt,
   output logic         reload
);
   logic [W-1:0] cnt_q;

   assign reload = en && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (start || force_ld) cnt_q <= load_next;
      else if (en)                cnt_q <= reload ? load_next : cnt_q - 1'b1;
   end

   assign cnt = cnt_q;

   // R2
   count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !reload && !start && !force_ld) |=> (cnt_q == $past(cnt_q) - 1'b1));

   // R11
   hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !start && !force_ld) |=> $stable(cnt_q));
endmodule

// File: rtl/pwm_deferred_timer.sv
module pwm_deferred_timer #(
   parameter int CNT_W = 16,
   parameter int PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   output logic             pwm_out,
   output logic             timeout
);
   import pwm_dr_pkg::*;

   localparam int W      = CNT_W + PRE_W;
   localparam int N_CH   = 2;
   localparam int CTRL_W = $bits(ctrl_t);

   if (CNT_W < CTRL_W) begin : g_bad_cnt
      $error("CNT_W must hold the control field");
   end
   if (2 * PRE_W > CNT_W) begin : g_bad_pre
      $error("both upper bytes must fit in one commit word");
   end
   if (PRE_W < 1) begin : g_bad_pre0
      $error("PRE_W must be at least 1");
   end

   ctrl_t        ctrl_q;
   adr_e         adr;
   logic         wr_ctrl, commit, start;
   logic [W-1:0] act   [N_CH];
   logic [W-1:0] nxt   [N_CH];
   logic         pend  [N_CH];
   logic [W-1:0] cnt;
   logic         reload;
   logic         raw;

   assign adr     = adr_e'(wr_addr);
   assign wr_ctrl = wr_en && (adr == ADR_CTRL);
   assign commit  = wr_en && (adr == ADR_COMMIT);
   assign start   = wr_ctrl && wr_data[0] && !ctrl_q.en;

   always_ff @(posedge clk) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
   end

   for (genvar i = 0; i < N_CH; i++) begin : g_ch
      localparam adr_e SEL = (i == 0) ? ADR_LOAD_LO : ADR_MATCH_LO;
      logic dfr;
      if (i == 0) begin : g_load
         assign dfr = ctrl_q.ldefer;
      end else begin : g_match
         assign dfr = ctrl_q.mdefer;
      end
      pwm_dr_shadow #(.LO_W(CNT_W), .HI_W(PRE_W)) u_sh (
         .clk      (clk),
         .rst_n    (rst_n),
         .stage_lo (wr_en && (adr == SEL)),
         .lo_data  (wr_data),
         .commit   (commit),
         .hi_data  (wr_data[i*PRE_W +: PRE_W]),
         .defer    (dfr),
         .reload   (reload),
         .restart  (start),
         .act_next (nxt[i]),
         .active   (act[i]),
         .pending  (pend[i])
      );
   end

   pwm_dr_counter #(.W(W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (ctrl_q.en),
      .start     (start),
      .force_ld  (commit && !ctrl_q.ldefer),
      .load_next (nxt[0]),
      .cnt       (cnt),
      .reload    (reload)
   );

   assign raw     = ctrl_q.en && (cnt <= act[1]);
   assign pwm_out = raw ^ ctrl_q.invert;
   assign timeout = reload;

   // R9
   joint_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reload && pend[0] && pend[1] && !commit) |=> (!pend[0] && !pend[1]));

   // R10
   restart_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && pend[0]) |=> !pend[0]);
endmodule

// File: tb/sim_pwm_deferred_timer.sv
`timescale 1ns/1ps
module sim_pwm_deferred_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = 2'd0;
   logic [15:0] wr_data = 16'd0;
   logic        pwm_out, timeout;

   always #4 clk = ~clk;

   pwm_deferred_timer u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                          .wr_data(wr_data), .pwm_out(pwm_out), .timeout(timeout));

   int checks = 0, fails = 0;
   string cur_req = "R1";
   bit done = 0;

   // behavioural reference state
   int m_en, m_ld, m_md, m_inv, m_lo_l, m_lo_m, m_al, m_am, m_pl, m_pm, m_ql, m_qm, m_cnt;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_en = 0; m_ld = 0; m_md = 0; m_inv = 0; m_lo_l = 0; m_lo_m = 0;
         m_al = 0; m_am = 0; m_pl = 0; m_pm = 0; m_ql = 0; m_qm = 0; m_cnt = 0;
      end else begin
         int cm, st, rl, cvl, cvm, nl, nm;
         cm  = (wr_en && wr_addr == 2'd3) ? 1 : 0;
         st  = (wr_en && wr_addr == 2'd0 && wr_data[0] && m_en == 0) ? 1 : 0;
         rl  = (m_en != 0 && m_cnt == 0) ? 1 : 0;
         cvl = (int'(wr_data[7:0]) << 16) | m_lo_l;
         cvm = (int'(wr_data[15:8]) << 16) | m_lo_m;
         nl = m_al; nm = m_am;
         if (cm != 0) begin
            if (m_ld != 0) begin m_pl = cvl; m_ql = 1; end else begin nl = cvl; m_ql = 0; end
            if (m_md != 0) begin m_pm = cvm; m_qm = 1; end else begin nm = cvm; m_qm = 0; end
         end else if (rl != 0 || st != 0) begin
            if (m_ql != 0) begin nl = m_pl; m_ql = 0; end
            if (m_qm != 0) begin nm = m_pm; m_qm = 0; end
         end
         if (st != 0 || (cm != 0 && m_ld == 0)) m_cnt = nl;
         else if (m_en != 0) m_cnt = (m_cnt == 0) ? nl : m_cnt - 1;
         m_al = nl; m_am = nm;
         if (wr_en && wr_addr == 2'd0) begin
            m_en = wr_data[0]; m_ld = wr_data[1]; m_md = wr_data[2]; m_inv = wr_data[3];
         end
         if (wr_en && wr_addr == 2'd1) m_lo_l = wr_data;
         if (wr_en && wr_addr == 2'd2) m_lo_m = wr_data;
      end
   end

   // per-clock comparison and pin-level period monitor
   int since = 0, hi_cnt = 0, last_per = 0, last_hi = 0, tmo_seen = 0;
   always @(negedge clk) begin
      int eo, et;
      eo = (m_en != 0) ? (((m_cnt <= m_am) ? 1 : 0) ^ m_inv) : m_inv;
      et = (m_en != 0 && m_cnt == 0) ? 1 : 0;
      if (!done) begin
         checks++;
         if (int'(pwm_out) != eo || int'(timeout) != et) begin
            fails++;
            $display("FAIL %s model: out=%0d tmo=%0d expected out=%0d tmo=%0d",
                     cur_req, pwm_out, timeout, eo, et);
         end
      end
      since++;
      if (pwm_out) hi_cnt++;
      if (timeout) begin
         last_per = since; last_hi = hi_cnt; since = 0; hi_cnt = 0; tmo_seen++;
      end
   end

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(posedge clk); #2;
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk); #2;
      wr_en = 1'b0;
   endtask

   task automatic wait_tmo(input int n);
      for (int k = 0; k < n; k++) begin
         int s;
         s = tmo_seen;
         wait (tmo_seen != s);
      end
   endtask

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk("R1", int'(pwm_out), 0);
      chk("R1", int'(timeout), 0);
      #2; rst_n = 1'b1;

      // R2 R3 basic period and high time
      cur_req = "R2";
      wr(2'd1, 16'd20); wr(2'd2, 16'd15); wr(2'd3, 16'h0000); wr(2'd0, 16'h0001);
      wait_tmo(2);
      chk("R2", last_per, 21);
      chk("R3", last_hi, 16);

      // R4 invert
      cur_req = "R4";
      wr(2'd0, 16'h0009);
      wait_tmo(2);
      chk("R4", last_hi, 5);
      wr(2'd0, 16'h0001);

      // R3 compare at or above period: constant high
      cur_req = "R3";
      wr(2'd2, 16'd25); wr(2'd3, 16'h0000);
      wait_tmo(2);
      chk("R3", last_hi, 21);

      // R8 staged low write alone has no effect
      cur_req = "R8";
      wr(2'd1, 16'd40);
      wait_tmo(2);
      chk("R8", last_per, 21);
      // R8 upper byte: period becomes 0x010028, no timeout for a long time
      wr(2'd3, 16'h0001);
      begin
         int s;
         s = tmo_seen;
         repeat (300) @(negedge clk);
         chk("R8", tmo_seen - s, 0);
      end

      // R5 immediate period restarts the counter
      cur_req = "R5";
      wr(2'd1, 16'd10); wr(2'd2, 16'd3); wr(2'd3, 16'h0000);
      wait_tmo(2);
      chk("R5", last_per, 11);
      chk("R5", last_hi, 4);

      // R6 deferred period: current period finishes
      cur_req = "R6";
      wr(2'd0, 16'h0007);
      wait_tmo(1);
      wr(2'd1, 16'd30); wr(2'd2, 16'd12); wr(2'd3, 16'h0000);
      wait_tmo(1);
      chk("R6", last_per, 11);
      chk("R6", last_hi, 4);
      wait_tmo(1);
      chk("R6", last_per, 31);
      chk("R6", last_hi, 13);

      // R9 shorter period below the old compare, both deferred
      cur_req = "R9";
      wait_tmo(1);
      wr(2'd1, 16'd5); wr(2'd2, 16'd2); wr(2'd3, 16'h0000);
      wait_tmo(1);
      chk("R9", last_per, 31);
      chk("R9", last_hi, 13);
      wait_tmo(1);
      chk("R9", last_per, 6);
      chk("R9", last_hi, 3);
      wait_tmo(1);
      chk("R9", last_per, 6);

      // R7 compare immediate while period deferred
      cur_req = "R7";
      wr(2'd0, 16'h0003);
      wr(2'd2, 16'd4); wr(2'd3, 16'h0000);
      wait_tmo(2);
      chk("R7", last_per, 6);
      chk("R7", last_hi, 5);

      // R10 restart applies waiting values at once
      cur_req = "R10";
      wr(2'd0, 16'h0006);
      wr(2'd1, 16'd8); wr(2'd2, 16'd1); wr(2'd3, 16'h0000);
      repeat (20) @(negedge clk);
      wr(2'd0, 16'h0007);
      wait_tmo(2);
      chk("R10", last_per, 9);
      chk("R10", last_hi, 2);

      // R11 disabled with invert: output follows invert, no timeout
      cur_req = "R11";
      wr(2'd0, 16'h0008);
      begin
         int hi, tm;
         hi = 0; tm = 0;
         for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (pwm_out) hi++;
            if (timeout) tm++;
         end
         chk("R11", hi, 20);
         chk("R11", tm, 0);
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule